// File: doc/BRIEF.md
# Link Hot Reset and Disable Sequencer

This block is the part of a downstream-facing port's link training state machine that carries the link through a hot reset or a disable and back to Detect. A register interface supplies two control bits. One asks for a secondary bus reset and the other asks for the link to be disabled. The receive lanes report each training set that arrives, together with its hot-reset flag and the link and lane numbers it carries. A free-running tick provides the timebase for the reset timeout.

While the reset control is asserted, the sequencer holds the Hot Reset state and asks every lane to send training sets with the hot-reset flag set. It clears LinkUp when any single lane has received two matching hot-reset training sets in a row. It returns to Detect only after the reset control is released, and only once either that pair has been seen or the timeout has run out. The disable control takes priority over everything else. It parks the link in Disabled with LinkUp low, and when it is cleared the link returns to Detect. An input from the rest of the training logic marks training complete, and this moves Detect to the active state with LinkUp set.

Top module: `hot_reset_seq`

## Requirements
- R1: After reset, `ltssm_state` is 0 (Detect), `link_up` is 0 and `tx_hot_ts` is 0.
- R2: In Detect, with neither control asserted, `train_done` moves the state to 1 (Active) at the next edge and sets `link_up`.
- R3: With `sbr_ctl` high and `dis_ctl` low, Detect or Active moves to state 2 (Hot Reset) at the next edge. `tx_hot_ts` is high exactly while the state is 2.
- R4: The state stays at 2 for as long as `sbr_ctl` is high, even after the timeout has expired and after a matching pair has been received.
- R5: In Hot Reset, a lane counts a training set as matching when `rx_ts_valid` is high, `rx_ts_hot` is 1, its link field equals `cfg_link_num` and its lane field equals the lane's own index. Two matching sets in a row on one lane clear `link_up` at the edge that samples the second set.
- R6: A valid training set on a lane that lacks the hot flag, or that carries a wrong link number or a wrong lane number, breaks that lane's run. Cycles with `rx_ts_valid` low leave the run intact.
- R7: Once a pair has been seen in the current Hot Reset, releasing `sbr_ctl` moves the state to 0 at the next edge, with `link_up` 0.
- R8: If no pair has been seen, Hot Reset exits to 0 only when `sbr_ctl` is low and 2*TICKS_PER_MS edges with `tb_tick` high have been sampled since entry. Edges with `tb_tick` low are not counted.
- R9: `dis_ctl` high moves any state to 3 (Disabled) at the next edge and clears `link_up`, even when `sbr_ctl` is also high. The state stays at 3 while `dis_ctl` is high. Once `dis_ctl` is low, it goes to 0 at the next edge with `link_up` 0.
- R10: Matching sets on different lanes do not combine into a pair. Each lane keeps its own run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| sbr_ctl | input | 1 | Secondary bus reset request from the register interface |
| dis_ctl | input | 1 | Link disable request from the register interface |
| train_done | input | 1 | Training from Detect completed by the rest of the state machine |
| tb_tick | input | 1 | Timebase tick, one cycle wide |
| cfg_link_num | input | LINK_W | Configured link number |
| rx_ts_valid | input | NUM_LANES | A training set arrived on a lane this cycle |
| rx_ts_hot | input | NUM_LANES | Hot-reset flag of that training set |
| rx_ts_link | input | NUM_LANES*LINK_W | Link number per lane, lane 0 in the low bits |
| rx_ts_lane | input | NUM_LANES*LANE_W | Lane number per lane, lane 0 in the low bits |
| ltssm_state | output | 2 | 0 Detect, 1 Active, 2 Hot Reset, 3 Disabled |
| link_up | output | 1 | LinkUp flag |
| tx_hot_ts | output | 1 | Request to send training sets with the hot-reset flag |

## Verification
The bench builds the block with NUM_LANES = 2 and TICKS_PER_MS = 2, which gives a timeout of four ticks. With that setting, an expired timeout under a held reset request and a timeout exit gated by idle tick cycles both take only a few cycles to reach. Two lanes are enough to show that matching sets spread across lanes never form a pair, and that a mismatch on one lane leaves the other lane's run alone.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [1:0] {
    ST_DETECT   = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_HOTRST   = 2'd2,
    ST_DISABLED = 2'd3
  } hrs_state_e;
endpackage

// File: rtl/hrs_lane_pair.sv
// Per-lane detector for two back-to-back matching hot-reset training sets.
module hrs_lane_pair #(
  parameter int LINK_W   = 8,
  parameter int LANE_W   = 5,
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,        // high while in Hot Reset
  input  logic              ts_valid,
  input  logic              ts_hot,
  input  logic [LINK_W-1:0] ts_link,
  input  logic [LANE_W-1:0] ts_lane,
  input  logic [LINK_W-1:0] cfg_link,
  output logic              pair_now
);
  logic prev_q, prev_d, good;

  assign good = ts_hot && (ts_link == cfg_link) && (ts_lane == LANE_W'(LANE_IDX));

  always_comb begin
    prev_d = prev_q;
    if (!arm)          prev_d = 1'b0;
    else if (ts_valid) prev_d = good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign pair_now = arm && ts_valid && good && prev_q;
endmodule

// File: rtl/hrs_timer.sv
// Counts timebase ticks while enabled; saturates at the limit.
module hrs_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == CW'(LIMIT));
  assign cnt_en  = !run || (tick && !expired);

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hot_reset_seq.sv
module hot_reset_seq
  import hrs_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int LINK_W       = 8,
  parameter int LANE_W       = 5,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sbr_ctl,
  input  logic                          dis_ctl,
  input  logic                          train_done,
  input  logic                          tb_tick,
  input  logic [LINK_W-1:0]             cfg_link_num,
  input  logic [NUM_LANES-1:0]          rx_ts_valid,
  input  logic [NUM_LANES-1:0]          rx_ts_hot,
  input  logic [NUM_LANES*LINK_W-1:0]   rx_ts_link,
  input  logic [NUM_LANES*LANE_W-1:0]   rx_ts_lane,
  output logic [1:0]                    ltssm_state,
  output logic                          link_up,
  output logic                          tx_hot_ts
);
  localparam int TIMEOUT_TICKS = 2 * TICKS_PER_MS;

  hrs_state_e            state_q, state_d;
  logic                  link_q, link_d;
  logic                  seen_q, seen_d;
  logic                  in_hr, expired, any_pair;
  logic [NUM_LANES-1:0]  lane_pair;

  assign in_hr = (state_q == ST_HOTRST);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    hrs_lane_pair #(
      .LINK_W  (LINK_W),
      .LANE_W  (LANE_W),
      .LANE_IDX(g)
    ) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (in_hr),
      .ts_valid(rx_ts_valid[g]),
      .ts_hot  (rx_ts_hot[g]),
      .ts_link (rx_ts_link[g*LINK_W +: LINK_W]),
      .ts_lane (rx_ts_lane[g*LANE_W +: LANE_W]),
      .cfg_link(cfg_link_num),
      .pair_now(lane_pair[g])
    );
  end

  assign any_pair = |lane_pair;

  hrs_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_hr),
    .tick   (tb_tick),
    .expired(expired)
  );

  // Next-state process
  always_comb begin
    state_d = state_q;
    link_d  = link_q;
    seen_d  = in_hr && (seen_q || any_pair);
    if (dis_ctl) begin
      state_d = ST_DISABLED;
      link_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_DETECT: begin
          if (sbr_ctl) state_d = ST_HOTRST;
          else if (train_done) begin
            state_d = ST_ACTIVE;
            link_d  = 1'b1;
          end
        end
        ST_ACTIVE: if (sbr_ctl) state_d = ST_HOTRST;
        ST_HOTRST: begin
          if (any_pair) link_d = 1'b0;
          if (!sbr_ctl && (seen_q || any_pair || expired)) begin
            state_d = ST_DETECT;
            link_d  = 1'b0;
          end
        end
        ST_DISABLED: begin
          state_d = ST_DETECT;
          link_d  = 1'b0;
        end
        default: state_d = ST_DETECT;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DETECT;
      link_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      link_q  <= link_d;
      seen_q  <= seen_d;
    end
  end

  assign ltssm_state = state_q;
  assign link_up     = link_q;
  assign tx_hot_ts   = in_hr;
endmodule

// File: rtl/hot_reset_seq_chk.sv
module hot_reset_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sbr_ctl,
  input logic       dis_ctl,
  input logic       train_done,
  input logic [1:0] ltssm_state,
  input logic       link_up,
  input logic       tx_hot_ts
);
  // R3
  enter_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbr_ctl && !dis_ctl && ltssm_state inside {2'd0, 2'd1}) |=> (ltssm_state == 2'd2 && tx_hot_ts));

  // R4
  hold_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbr_ctl && !dis_ctl && ltssm_state == 2'd2) |=> (ltssm_state == 2'd2));

  // R9
  disable_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ctl |=> (ltssm_state == 2'd3 && !link_up));

  // R9
  disable_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_ctl && ltssm_state == 2'd3) |=> (ltssm_state == 2'd0 && !link_up));

  // R2
  train_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ltssm_state == 2'd0 && train_done && !sbr_ctl && !dis_ctl) |=> (ltssm_state == 2'd1 && link_up));

  // R7
  detect_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ltssm_state == 2'd0) |-> !link_up);
endmodule

bind hot_reset_seq hot_reset_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sbr_ctl    (sbr_ctl),
  .dis_ctl    (dis_ctl),
  .train_done (train_done),
  .ltssm_state(ltssm_state),
  .link_up    (link_up),
  .tx_hot_ts  (tx_hot_ts)
);

// File: tb/hot_reset_seq_tb_top.sv
`timescale 1ns/1ps
module hot_reset_seq_tb_top;
  localparam int NL  = 2;
  localparam int LW  = 8;
  localparam int NW  = 5;
  localparam int TPM = 2;
  localparam int TO  = 2 * TPM;
  localparam logic [LW-1:0] CFG = 8'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sbr = 1'b0, dis = 1'b0, train = 1'b0, tick = 1'b0;
  logic [NL-1:0] v = '0, h = '0;
  logic [LW-1:0] lk [NL];
  logic [NW-1:0] ln [NL];
  logic [NL*LW-1:0] lk_flat;
  logic [NL*NW-1:0] ln_flat;
  logic [1:0] st;
  logic lu, txh;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NL; g++) begin : g_flat
    assign lk_flat[g*LW +: LW] = lk[g];
    assign ln_flat[g*NW +: NW] = ln[g];
  end

  hot_reset_seq #(.NUM_LANES(NL), .LINK_W(LW), .LANE_W(NW), .TICKS_PER_MS(TPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .sbr_ctl(sbr), .dis_ctl(dis), .train_done(train),
    .tb_tick(tick), .cfg_link_num(CFG), .rx_ts_valid(v), .rx_ts_hot(h),
    .rx_ts_link(lk_flat), .rx_ts_lane(ln_flat),
    .ltssm_state(st), .link_up(lu), .tx_hot_ts(txh)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  int m_state = 0;
  bit m_link = 1'b0, m_seen = 1'b0;
  int m_ticks = 0;
  bit m_prev [NL];

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit lane_good(int i);
    return h[i] && lk[i] == CFG && ln[i] == NW'(i);
  endfunction

  task automatic model_step();
    bit pair = 1'b0;
    int ns = m_state;
    bit nl = m_link;
    bit hr = (m_state == 2);
    if (hr) for (int i = 0; i < NL; i++) if (v[i] && lane_good(i) && m_prev[i]) pair = 1'b1;
    if (dis) begin ns = 3; nl = 1'b0; end
    else if (m_state == 0) begin
      if (sbr) ns = 2;
      else if (train) begin ns = 1; nl = 1'b1; end
    end else if (m_state == 1) begin
      if (sbr) ns = 2;
    end else if (m_state == 2) begin
      if (pair) nl = 1'b0;
      if (!sbr && (m_seen || pair || m_ticks >= TO)) begin ns = 0; nl = 1'b0; end
    end else begin
      ns = 0; nl = 1'b0;
    end
    for (int i = 0; i < NL; i++) m_prev[i] = hr ? (v[i] ? lane_good(i) : m_prev[i]) : 1'b0;
    m_seen  = hr && (m_seen || pair);
    m_ticks = hr ? ((tick && m_ticks < TO) ? m_ticks + 1 : m_ticks) : 0;
    m_state = ns;
    m_link  = nl;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, {st, lu, txh}, {m_state[1:0], m_link, m_state == 2});
    v = '0; h = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic send(int lane, bit hot, logic [LW-1:0] link, logic [NW-1:0] lnum);
    v[lane] = 1'b1; h[lane] = hot; lk[lane] = link; ln[lane] = lnum;
    cyc();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin lk[i] = '0; ln[i] = '0; m_prev[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1", {st, lu, txh}, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", st, 0);

    // R2: training completes
    cur_req = "R2";
    train = 1'b1; cyc(); train = 1'b0;
    chk("R2", {st, lu}, {2'd1, 1'b1});

    // R4/R8: timeout expires under a held request, exit only after release
    cur_req = "R4";
    sbr = 1'b1; tick = 1'b1; cyc();
    chk("R3", {st, txh}, {2'd2, 1'b1});
    idle(10);
    chk("R4", {st, lu}, {2'd2, 1'b1});
    cur_req = "R8";
    sbr = 1'b0; tick = 1'b0; cyc();
    chk("R8", {st, lu, txh}, 0);

    // R5/R6: broken runs, idle gap, then a real pair
    cur_req = "R6";
    train = 1'b1; cyc(); train = 1'b0;
    sbr = 1'b1; cyc();
    send(0, 1'b1, CFG, 5'd0);
    send(0, 1'b0, CFG, 5'd0);
    send(0, 1'b1, CFG, 5'd0);
    send(0, 1'b1, 8'h11, 5'd0);
    send(0, 1'b1, CFG, 5'd0);
    send(0, 1'b1, CFG, 5'd1);
    chk("R6", {st, lu}, {2'd2, 1'b1});
    cur_req = "R5";
    send(0, 1'b1, CFG, 5'd0);
    idle(2);
    send(0, 1'b1, CFG, 5'd0);
    chk("R5", {st, lu}, {2'd2, 1'b0});
    cur_req = "R4";
    idle(3);
    chk("R4", st, 2);
    cur_req = "R7";
    sbr = 1'b0; cyc();
    chk("R7", {st, lu}, {2'd0, 1'b0});

    // R10: alternating lanes never pair; R8 tick gating
    cur_req = "R10";
    train = 1'b1; cyc(); train = 1'b0;
    sbr = 1'b1; cyc();
    send(0, 1'b1, CFG, 5'd0);
    send(1, 1'b1, CFG, 5'd1);
    send(0, 1'b0, CFG, 5'd0);
    send(1, 1'b0, CFG, 5'd1);
    chk("R10", {st, lu}, {2'd2, 1'b1});
    cur_req = "R8";
    sbr = 1'b0; idle(3);
    chk("R8", st, 2);
    tick = 1'b1; cyc(); tick = 1'b0; idle(2);
    chk("R8", st, 2);
    tick = 1'b1; idle(3);
    chk("R8", st, 2);
    cyc(); tick = 1'b0;
    chk("R8", {st, lu}, {2'd0, 1'b0});

    // R9: disable beats reset request, hold, then release
    cur_req = "R9";
    train = 1'b1; cyc(); train = 1'b0;
    dis = 1'b1; sbr = 1'b1; cyc();
    chk("R9", {st, lu, txh}, {2'd3, 1'b0, 1'b0});
    idle(4);
    chk("R9", st, 3);
    sbr = 1'b0; dis = 1'b0; cyc();
    chk("R9", {st, lu}, {2'd0, 1'b0});
    // disable while in Hot Reset
    sbr = 1'b1; cyc();
    chk("R3", st, 2);
    dis = 1'b1; cyc();
    chk("R9", st, 3);
    dis = 1'b0; sbr = 1'b0; cyc();
    chk("R9", st, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule